// File: doc/BRIEF.md
# Indirect Video Memory Register Port

This block lets a CPU reach a video memory that is not mapped into its address space. The CPU sees a small bank of 8-bit registers. One of them is a data window: each access to it reads or writes the video byte at a 14-bit pointer held in two other registers, and the pointer then steps by one. Three further registers hold display settings (a mode byte, a text line scroll and a text page). They drive the display logic directly from the moment they are written.

Writes through the data window do not touch memory at once. The byte and its address go into a write queue, which empties into video memory on any cycle when the display side has not claimed the memory (`vram_busy` low). When the queue is full, the CPU is held off with `ready` low. A read through the data window first waits until the queue has emptied, so it always sees the CPU's latest writes. It then waits for a free memory cycle and issues one read. `ready` stays low until the byte is available.

Read handling is a four-state machine. RD_IDLE moves to RD_WAIT when a data-window read arrives. RD_WAIT moves to RD_FETCH in the cycle it issues the memory read, which requires an empty queue and `vram_busy` low. RD_FETCH moves to RD_DONE while it captures the returned byte. RD_DONE returns to RD_IDLE as the CPU access completes.

Top module: `vram_regport`

## Requirements
- R1: After reset all registers and the address pointer are zero, the write queue is empty, `ready` is high while `cs` is low, and neither `vram_we` nor `vram_re` is asserted.
- R2: A CPU access completes on a rising edge where `cs` and `ready` are both high. `rw`=1 means read and `rw`=0 means write. Writes to select 3 (mode), 4 (line scroll) and 5 (text page) complete without wait. Each register changes at that edge, and the new value is visible on its output and on `rdata` from the next cycle. No other access changes these registers.
- R3: Select 1 holds pointer bits 7:0. Select 2 holds pointer bits 13:8, taken from `wdata[5:0]`. A read of select 2 returns the high bits with bits 7:6 zero.
- R4: A write to select 0 while the queue is not full completes without wait and queues the pair {pointer, `wdata`}.
- R5: A write to select 0 while the queue (16 entries) is full holds `ready` low until an entry drains. The write then completes, and no byte is lost.
- R6: Queued writes leave on `vram_we`/`vram_addr`/`vram_wdata` in the order they were queued, one per cycle in which `vram_busy` is low. No memory access is made while `vram_busy` is high. An entry queued at an edge may leave in the very next cycle.
- R7: A read of select 0 keeps `ready` low until the queue is empty and `vram_busy` is low. It then asserts `vram_re` for one cycle with the pointer on `vram_addr`, and takes `vram_rdata` one cycle later. `ready` rises, with that byte on `rdata`, in the cycle after that. The byte is the one most recently written to that address.
- R8: Every completed select-0 access, read or write, advances the pointer by one. The pointer wraps from 0x3FFF to 0x0000.
- R9: Writes to selects 6 and 7 change nothing. Reads of them complete without wait and return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | CPU access request |
| rw | input | 1 | 1 = read, 0 = write |
| sel | input | 3 | Register select |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | CPU read data |
| ready | output | 1 | Low holds the CPU access |
| vram_busy | input | 1 | Display side owns video memory this cycle |
| vram_we | output | 1 | Memory write strobe |
| vram_re | output | 1 | Memory read strobe |
| vram_addr | output | 14 | Memory address |
| vram_wdata | output | 8 | Memory write data |
| vram_rdata | input | 8 | Memory read data, valid one cycle after `vram_re` |
| mode_q | output | 8 | Mode control setting |
| scroll_q | output | 8 | Text line scroll setting |
| page_q | output | 8 | Text page setting |

## Verification
Register writes take effect at the completing edge, so their outputs are sampled at the following falling edge. A queued write can appear on the memory port in the cycle right after its push. A scoreboard therefore pushes each expected {address, byte} when the write is issued, and a monitor pops and compares at every falling edge that shows `vram_we`, which makes the check independent of the queue's latency. A data-window read with an empty queue and a free memory raises `ready` three cycles after it is presented. The bench waits for `ready` at falling edges and takes `rdata` in that same half cycle. While the queue is full or the memory is claimed, `ready` is checked low at each falling edge over a fixed window before `vram_busy` is released.

// File: rtl/vrp_pkg.sv
package vrp_pkg;

    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_DATA   = 3'd0;
    localparam logic [SEL_W-1:0] SEL_PTR_LO = 3'd1;
    localparam logic [SEL_W-1:0] SEL_PTR_HI = 3'd2;
    localparam logic [SEL_W-1:0] SEL_MODE   = 3'd3;
    localparam logic [SEL_W-1:0] SEL_SCROLL = 3'd4;
    localparam logic [SEL_W-1:0] SEL_PAGE   = 3'd5;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_WAIT,
        RD_FETCH,
        RD_DONE
    } rd_state_t;

endpackage

// File: rtl/vrp_fifo.sv
module vrp_fifo #(
    parameter int W     = 22,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) store[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = store[rd_ptr];
    assign full  = (count == DEPTH_C);
    assign empty = (count == '0);

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_C);
endmodule

// File: rtl/vrp_regs.sv
module vrp_regs
    import vrp_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    input  logic              adv,
    output logic [ADDR_W-1:0] ptr,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] scroll_q,
    output logic [DATA_W-1:0] page_q,
    output logic [DATA_W-1:0] rd_val
);
    localparam int HI_W = ADDR_W - DATA_W;

    logic [DATA_W-1:0] ptr_lo;
    logic [HI_W-1:0]   ptr_hi;

    assign ptr = {ptr_hi, ptr_lo};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_lo   <= '0;
            ptr_hi   <= '0;
            mode_q   <= '0;
            scroll_q <= '0;
            page_q   <= '0;
        end else begin
            if (adv) begin
                {ptr_hi, ptr_lo} <= ptr + 1'b1;
            end else if (wr_en) begin
                unique case (sel)
                    SEL_PTR_LO: ptr_lo <= wdata;
                    SEL_PTR_HI: ptr_hi <= wdata[HI_W-1:0];
                    default: ;
                endcase
            end
            if (wr_en) begin
                unique case (sel)
                    SEL_MODE:   mode_q   <= wdata;
                    SEL_SCROLL: scroll_q <= wdata;
                    SEL_PAGE:   page_q   <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (sel)
            SEL_PTR_LO: rd_val = ptr_lo;
            SEL_PTR_HI: rd_val = DATA_W'(ptr_hi);
            SEL_MODE:   rd_val = mode_q;
            SEL_SCROLL: rd_val = scroll_q;
            SEL_PAGE:   rd_val = page_q;
            default:    rd_val = '0;
        endcase
    end

    a_r8_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> ptr == ADDR_W'($past(ptr) + 1'b1));
    a_r2_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == SEL_MODE) |=> $stable(mode_q));
    a_r2_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == SEL_PAGE) |=> $stable(page_q));
endmodule

// File: rtl/vrp_rd_fsm.sv
module vrp_rd_fsm
    import vrp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              fifo_empty,
    input  logic              vram_busy,
    input  logic [DATA_W-1:0] vram_rdata,
    output logic              vram_re,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data
);
    rd_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RD_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RD_IDLE:  if (rd_req) state_nx = RD_WAIT;
            RD_WAIT:  if (fifo_empty && !vram_busy) state_nx = RD_FETCH;
            RD_FETCH: state_nx = RD_DONE;
            RD_DONE:  state_nx = RD_IDLE;
            default:  state_nx = RD_IDLE;
        endcase
    end

    always_comb begin
        vram_re = 1'b0;
        rd_done = 1'b0;
        unique case (state)
            RD_WAIT:  vram_re = fifo_empty && !vram_busy;
            RD_DONE:  rd_done = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                 rd_data <= '0;
        else if (state == RD_FETCH) rd_data <= vram_rdata;
    end

    a_r7_read_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        vram_re |-> fifo_empty && !vram_busy);
    a_r7_fetch_follows_re: assert property (@(posedge clk) disable iff (!rst_n)
        state == RD_FETCH |-> $past(vram_re));
    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);
endmodule

// File: rtl/vram_regport.sv
module vram_regport
    import vrp_pkg::*;
#(
    parameter int ADDR_W     = 14,
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              rw,
    input  logic [2:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    input  logic              vram_busy,
    output logic              vram_we,
    output logic              vram_re,
    output logic [ADDR_W-1:0] vram_addr,
    output logic [DATA_W-1:0] vram_wdata,
    input  logic [DATA_W-1:0] vram_rdata,
    output logic [DATA_W-1:0] mode_q,
    output logic [DATA_W-1:0] scroll_q,
    output logic [DATA_W-1:0] page_q
);
    localparam int ENT_W = ADDR_W + DATA_W;

    logic              data_sel, rd_req, wr_req, push, pop;
    logic              fifo_full, fifo_empty, rd_done, adv, rd_re;
    logic [ENT_W-1:0]  head;
    logic [ADDR_W-1:0] ptr;
    logic [DATA_W-1:0] reg_val, rd_data;

    assign data_sel = (sel == SEL_DATA);
    assign rd_req   = cs && rw && data_sel;
    assign wr_req   = cs && !rw && data_sel;
    assign push     = wr_req && !fifo_full;
    assign pop      = !fifo_empty && !vram_busy;
    assign adv      = push || rd_done;

    vrp_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   ({ptr, wdata}),
        .pop   (pop),
        .head  (head),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    vrp_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cs && !rw),
        .sel      (sel),
        .wdata    (wdata),
        .adv      (adv),
        .ptr      (ptr),
        .mode_q   (mode_q),
        .scroll_q (scroll_q),
        .page_q   (page_q),
        .rd_val   (reg_val)
    );

    vrp_rd_fsm #(.DATA_W(DATA_W)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_req     (rd_req),
        .fifo_empty (fifo_empty),
        .vram_busy  (vram_busy),
        .vram_rdata (vram_rdata),
        .vram_re    (rd_re),
        .rd_done    (rd_done),
        .rd_data    (rd_data)
    );

    always_comb begin
        ready      = 1'b1;
        if (rd_req && !rd_done) ready = 1'b0;
        if (wr_req && fifo_full) ready = 1'b0;
        rdata      = data_sel ? rd_data : reg_val;
        vram_we    = pop;
        vram_re    = rd_re;
        vram_wdata = head[DATA_W-1:0];
        vram_addr  = rd_re ? ptr : head[ENT_W-1:DATA_W];
    end

    a_r6_idle_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        vram_busy |-> !vram_we && !vram_re);
    a_r6_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(vram_we && vram_re));
    a_r5_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && fifo_full) |-> !ready);
    a_r2_cfg_no_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && !data_sel) |-> ready);
endmodule

// File: tb/vram_regport_test.sv
module vram_regport_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, rw = 1'b1;
    logic [2:0]  sel = '0;
    logic [7:0]  wdata = '0, rdata;
    logic        ready, vram_busy = 1'b0, vram_we, vram_re;
    logic [13:0] vram_addr;
    logic [7:0]  vram_wdata, vram_rdata = '0;
    logic [7:0]  mode_q, scroll_q, page_q;

    int checks = 0, fails = 0;
    logic [21:0] exp_q[$];
    logic [13:0] exp_ptr = '0;
    logic [7:0]  mem [int];
    logic        done = 1'b0;

    vram_regport uut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rw(rw), .sel(sel), .wdata(wdata),
        .rdata(rdata), .ready(ready), .vram_busy(vram_busy), .vram_we(vram_we),
        .vram_re(vram_re), .vram_addr(vram_addr), .vram_wdata(vram_wdata),
        .vram_rdata(vram_rdata), .mode_q(mode_q), .scroll_q(scroll_q), .page_q(page_q)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (vram_we) mem[int'(vram_addr)] = vram_wdata;
        if (vram_re) vram_rdata <= mem.exists(int'(vram_addr)) ? mem[int'(vram_addr)] : 8'h00;
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // scoreboard monitor (R6): every drained entry must match the next queued one
    always @(negedge clk) begin
        #4;
        if (rst_n && vram_we) begin
            if (exp_q.size() == 0) check(1'b0, "R6 unexpected drain", int'(vram_addr), -1);
            else begin
                logic [21:0] e;
                e = exp_q.pop_front();
                check({vram_addr, vram_wdata} == e, "R6 drain order", int'({vram_addr, vram_wdata}), int'(e));
            end
        end
        if (rst_n && vram_busy) check(!vram_we && !vram_re, "R6 no access while busy", int'({vram_we, vram_re}), 0);
    end

    task automatic cpu(input logic rd, input logic [2:0] s, input logic [7:0] d, output logic [7:0] q);
        @(negedge clk);
        cs = 1'b1; rw = rd; sel = s; wdata = d;
        #1;
        while (!ready) begin
            @(negedge clk);
            #1;
        end
        q = rdata;
        @(posedge clk);
        #1;
        cs = 1'b0; rw = 1'b1; sel = '0;
        if (s == 3'd0) begin
            if (!rd) exp_q.push_back({exp_ptr, d});
            exp_ptr = exp_ptr + 1'b1;
        end else if (!rd && s == 3'd1) exp_ptr[7:0] = d;
        else if (!rd && s == 3'd2) exp_ptr[13:8] = d[5:0];
    endtask

    task automatic set_ptr(input logic [13:0] a);
        logic [7:0] q;
        cpu(1'b0, 3'd1, a[7:0], q);
        cpu(1'b0, 3'd2, {2'b00, a[13:8]}, q);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] q;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #2;
        // R1 reset state
        check(ready && !vram_we && !vram_re, "R1 idle outputs", int'({ready, vram_we, vram_re}), 4);
        check(mode_q == 0 && scroll_q == 0 && page_q == 0, "R1 config zero", int'({mode_q, scroll_q, page_q}), 0);

        // R2 config registers
        cpu(1'b0, 3'd3, 8'h5A, q);
        cpu(1'b0, 3'd4, 8'h07, q);
        cpu(1'b0, 3'd5, 8'hC3, q);
        @(negedge clk); #2;
        check(mode_q == 8'h5A, "R2 mode", int'(mode_q), 'h5A);
        check(scroll_q == 8'h07, "R2 scroll", int'(scroll_q), 'h07);
        check(page_q == 8'hC3, "R2 page", int'(page_q), 'hC3);
        cpu(1'b1, 3'd3, 8'h00, q);
        check(q == 8'h5A, "R2 mode readback", int'(q), 'h5A);

        // R3 pointer registers
        set_ptr(14'h0000);
        cpu(1'b0, 3'd2, 8'hFF, q);
        exp_ptr[13:8] = 6'h3F;
        cpu(1'b1, 3'd2, 8'h00, q);
        check(q == 8'h3F, "R3 high byte masked", int'(q), 'h3F);
        cpu(1'b0, 3'd1, 8'h12, q);
        cpu(1'b1, 3'd1, 8'h00, q);
        check(q == 8'h12, "R3 low byte", int'(q), 'h12);

        // R4 R6 writes drain in order
        set_ptr(14'h0200);
        for (int i = 0; i < 6; i++) cpu(1'b0, 3'd0, 8'(8'h30 + i), q);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R4 all writes drained", exp_q.size(), 0);

        // R8 wrap at top of space
        set_ptr(14'h3FFF);
        cpu(1'b0, 3'd0, 8'hE1, q);
        cpu(1'b0, 3'd0, 8'hE2, q);
        cpu(1'b1, 3'd1, 8'h00, q);
        check(q == 8'h01, "R8 pointer wrapped low", int'(q), 1);
        cpu(1'b1, 3'd2, 8'h00, q);
        check(q == 8'h00, "R8 pointer wrapped high", int'(q), 0);

        // R5 full queue stalls until busy drops
        vram_busy = 1'b1;
        set_ptr(14'h1000);
        for (int i = 0; i < 16; i++) cpu(1'b0, 3'd0, 8'(8'h80 + i), q);
        fork
            cpu(1'b0, 3'd0, 8'hAA, q);
            begin
                @(negedge clk); #2;
                for (int k = 0; k < 5; k++) begin
                    check(!ready, "R5 stall while full", int'(ready), 0);
                    @(negedge clk); #2;
                end
                vram_busy = 1'b0;
            end
        join
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R5 no byte lost", exp_q.size(), 0);

        // R7 read waits for queue and memory, returns own write
        vram_busy = 1'b1;
        set_ptr(14'h0100);
        cpu(1'b0, 3'd0, 8'hA5, q);
        cpu(1'b0, 3'd0, 8'h5C, q);
        set_ptr(14'h0100);
        fork
            cpu(1'b1, 3'd0, 8'h00, q);
            begin
                @(negedge clk); #2;
                for (int k = 0; k < 4; k++) begin
                    check(!ready, "R7 stall while busy", int'(ready), 0);
                    @(negedge clk); #2;
                end
                vram_busy = 1'b0;
            end
        join
        check(q == 8'hA5, "R7 read own write", int'(q), 'hA5);
        cpu(1'b1, 3'd0, 8'h00, q);
        check(q == 8'h5C, "R8 read advances pointer", int'(q), 'h5C);

        // R7 latency with idle memory: ready rises three cycles after request
        set_ptr(14'h0200);
        @(negedge clk);
        cs = 1'b1; rw = 1'b1; sel = 3'd0;
        #1 check(!ready, "R7 latency c0", int'(ready), 0);
        @(negedge clk); #1 check(!ready, "R7 latency c1", int'(ready), 0);
        @(negedge clk); #1 check(!ready, "R7 latency c2", int'(ready), 0);
        @(negedge clk); #1 check(ready && rdata == 8'h30, "R7 latency c3", int'({ready, rdata}), 'h130);
        @(posedge clk); #1 cs = 1'b0; sel = '0;
        exp_ptr = exp_ptr + 1'b1;

        // R9 unused selects
        cpu(1'b0, 3'd6, 8'h77, q);
        cpu(1'b0, 3'd7, 8'h66, q);
        cpu(1'b1, 3'd6, 8'h00, q);
        check(q == 8'h00, "R9 read select 6", int'(q), 0);
        cpu(1'b1, 3'd7, 8'h00, q);
        check(q == 8'h00, "R9 read select 7", int'(q), 0);
        @(negedge clk); #2;
        check(mode_q == 8'h5A && scroll_q == 8'h07 && page_q == 8'hC3, "R9 config untouched",
              int'({mode_q, scroll_q, page_q}), 'h5A07C3);
        cpu(1'b1, 3'd1, 8'h00, q);
        check(q == 8'h01, "R9 pointer untouched", int'(q), 1);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R6 scoreboard empty", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule